// File: doc/BRIEF.md
# Ratio Source Selection Controller

This block picks the reference source and the multiplier ratio slot that drive a fractional-N frequency synthesizer. A two-bit mode input picks one of four configuration slots. Each slot brings in a two-bit lock-clock pointer and a manual source bit. A slot whose pointer names another slot runs in automatic mode. In that mode the block tracks whether the input clock is toggling. While the clock is present it selects the dynamic (hybrid) ratio path, using the ratio slot named by the pointer. When the clock disappears it waits a long timeout with lock withdrawn, then falls back to the reference clock and the active slot's own static ratio.

A slot whose pointer equals its own index runs in manual mode, and its source bit decides the source. A global override pin, enabled by a three-bit configuration code, can take control from both modes. The outputs are registered in the system-clock domain. They give the chosen source, the index of the ratio slot in use and a lock-valid flag.

The automatic path is a four-state machine. REF_SYNTH selects the reference source with lock valid. DYN_HYBRID selects the dynamic source with lock valid. LOSS_WAIT holds the dynamic source with lock withdrawn while the timeout runs. RELOCK lasts one cycle with lock withdrawn and leads into the dynamic source. Its transitions are:

- reset enters REF_SYNTH.
- REF_SYNTH goes to RELOCK when the clock is present.
- RELOCK goes to DYN_HYBRID unconditionally.
- DYN_HYBRID goes to LOSS_WAIT when the clock is declared absent.
- LOSS_WAIT goes to REF_SYNTH when the timeout expires.
- LOSS_WAIT goes to RELOCK when the clock is present again.

Top module: `ratio_src_ctrl`

## Requirements
- R1: While reset is asserted, src_dyn is 0, ratio_idx is 0 and lock_ok is 0.
- R2: mode_sel picks slot s. The slot's pointer is lock_ptr_flat[2s+1:2s] and its manual bit is man_src[s]. Automatic mode is enabled exactly when the pointer differs from s.
- R3: In manual mode with the override inactive, src_dyn equals man_src[s] one cycle after the inputs settle. ratio_idx is s, and lock_ok is 1.
- R4: In automatic mode with the input clock present, src_dyn is 1, ratio_idx equals the pointer, and lock_ok is 1. The manual bit is ignored.
- R5: In automatic mode after the timeout has expired with the clock absent, src_dyn is 0, ratio_idx is s, and lock_ok is 1.
- R6: After the clock is declared absent, lock_ok is 0 for exactly TIMEOUT_CYC consecutive cycles, and src_dyn stays 1 during that time. The block then switches to the reference source.
- R7: The input clock is declared absent after ABSENT_CYC system cycles without a detected rising edge. It is declared present after RETURN_EDGES detected edges with no such gap.
- R8: When the clock returns, src_dyn switches to 1 and lock_ok is 0 for exactly one cycle.
- R9: When ovr_cfg is 3'b011, ovr_pin decides src_dyn (1 = dynamic, 0 = reference), overriding both modes. ratio_idx is then the pointer if the pin is 1 and s otherwise, and lock_ok is 1. Any other ovr_cfg value leaves the pin without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Active configuration slot |
| lock_ptr_flat | input | 8 | Four two-bit lock-clock pointers, slot s at bits [2s+1:2s] |
| man_src | input | 4 | Manual source bit per slot (1 = dynamic) |
| ovr_pin | input | 1 | Override source level |
| ovr_cfg | input | 3 | Global override configuration code |
| in_clk | input | 1 | Monitored input clock, asynchronous |
| src_dyn | output | 1 | Selected source: 1 dynamic, 0 reference |
| ratio_idx | output | 2 | Ratio slot in use |
| lock_ok | output | 1 | Lock valid |

## Verification
If the state machine holds a wrong state, src_dyn or lock_ok shows a stale value at the ports one cycle after the register update. This is visible whenever the active slot is in automatic mode and no override applies. A wrong pointer decode shows on ratio_idx in the next cycle. A timeout counter that is off by any amount shows as a lock-low window of the wrong length, and the bench measures that length to the cycle. A presence detector with a wrong threshold delays or advances the fallback and the relock pulse by a measurable number of cycles.

// File: rtl/ratio_src_pkg.sv
package ratio_src_pkg;
    typedef enum logic [1:0] {
        REF_SYNTH  = 2'd0,
        DYN_HYBRID = 2'd1,
        LOSS_WAIT  = 2'd2,
        RELOCK     = 2'd3
    } rsel_state_t;

    localparam logic [2:0] OVR_CODE = 3'b011;
endpackage

// File: rtl/ratio_clk_presence.sv
module ratio_clk_presence #(
    parameter int ABSENT_CYC   = 16,
    parameter int RETURN_EDGES = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_clk,
    output logic present_o
);
    localparam int GAP_W = $clog2(ABSENT_CYC + 1);
    localparam int RUN_W = $clog2(RETURN_EDGES + 1);

    logic [SYNC_STAGES:0] sync_q;
    logic                 edge_det;
    logic [GAP_W-1:0]     gap_q;
    logic [RUN_W-1:0]     run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], in_clk};
    end

    assign edge_det = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q     <= '0;
            run_q     <= '0;
            present_o <= 1'b0;
        end else if (edge_det) begin
            gap_q <= '0;
            if (run_q != RUN_W'(RETURN_EDGES)) run_q <= run_q + 1'b1;
            if (run_q == RUN_W'(RETURN_EDGES - 1)) present_o <= 1'b1;
        end else begin
            if (gap_q != GAP_W'(ABSENT_CYC)) gap_q <= gap_q + 1'b1;
            if (gap_q == GAP_W'(ABSENT_CYC - 1)) begin
                present_o <= 1'b0;
                run_q     <= '0;
            end
        end
    end

    // R7
    edge_keeps_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det |=> !$fell(present_o));
endmodule

// File: rtl/ratio_auto_fsm.sv
module ratio_auto_fsm
    import ratio_src_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1 << 23
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        present_i,
    output rsel_state_t state_o
);
    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

    rsel_state_t      state_q, state_d;
    logic [TMR_W-1:0] tmr_q;
    logic             tmr_done;

    assign tmr_done = (tmr_q == TMR_W'(TIMEOUT_CYC - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REF_SYNTH:  if (present_i) state_d = RELOCK;
            RELOCK:     state_d = DYN_HYBRID;
            DYN_HYBRID: if (!present_i) state_d = LOSS_WAIT;
            LOSS_WAIT: begin
                if (present_i)     state_d = RELOCK;
                else if (tmr_done) state_d = REF_SYNTH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REF_SYNTH;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == LOSS_WAIT) tmr_q <= tmr_q + 1'b1;
            else                      tmr_q <= '0;
        end
    end

    assign state_o = state_q;

    // R8
    relock_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RELOCK) |=> (state_q == DYN_HYBRID));
    // R6
    loss_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DYN_HYBRID && !present_i) |=> (state_q == LOSS_WAIT));
    // R8
    loss_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LOSS_WAIT && present_i) |=> (state_q == RELOCK));
endmodule

// File: rtl/ratio_src_ctrl.sv
module ratio_src_ctrl
    import ratio_src_pkg::*;
#(
    parameter int SLOT_W       = 2,
    parameter int TIMEOUT_CYC  = 1 << 23,
    parameter int ABSENT_CYC   = 16,
    parameter int RETURN_EDGES = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SLOT_W-1:0]             mode_sel,
    input  logic [SLOT_W*(1<<SLOT_W)-1:0] lock_ptr_flat,
    input  logic [(1<<SLOT_W)-1:0]        man_src,
    input  logic                          ovr_pin,
    input  logic [2:0]                    ovr_cfg,
    input  logic                          in_clk,
    output logic                          src_dyn,
    output logic [SLOT_W-1:0]             ratio_idx,
    output logic                          lock_ok
);
    localparam int NUM_SLOTS = 1 << SLOT_W;

    logic [SLOT_W-1:0] ptr_arr [NUM_SLOTS];
    logic [SLOT_W-1:0] ptr_act;
    logic              man_bit, auto_en, ovr_act, present;
    logic              src_d, lock_d;
    logic [SLOT_W-1:0] idx_d;
    rsel_state_t       auto_state;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign ptr_arr[g] = lock_ptr_flat[g*SLOT_W +: SLOT_W];
    end

    assign ptr_act = ptr_arr[mode_sel];
    assign man_bit = man_src[mode_sel];
    assign auto_en = (ptr_act != mode_sel);
    assign ovr_act = (ovr_cfg == OVR_CODE);

    ratio_clk_presence #(
        .ABSENT_CYC  (ABSENT_CYC),
        .RETURN_EDGES(RETURN_EDGES),
        .SYNC_STAGES (SYNC_STAGES)
    ) presence_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_clk   (in_clk),
        .present_o(present)
    );

    ratio_auto_fsm #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .present_i(present),
        .state_o  (auto_state)
    );

    always_comb begin
        lock_d = 1'b1;
        if (ovr_act) begin
            src_d = ovr_pin;
        end else if (!auto_en) begin
            src_d = man_bit;
        end else begin
            src_d  = (auto_state != REF_SYNTH);
            lock_d = (auto_state == REF_SYNTH) || (auto_state == DYN_HYBRID);
        end
        idx_d = src_d ? ptr_act : mode_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_dyn   <= 1'b0;
            ratio_idx <= '0;
            lock_ok   <= 1'b0;
        end else begin
            src_dyn   <= src_d;
            ratio_idx <= idx_d;
            lock_ok   <= lock_d;
        end
    end

    // R9
    ovr_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_act |=> (src_dyn == $past(ovr_pin)) && lock_ok);
    // R3
    manual_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_act && !auto_en) |=> (src_dyn == $past(man_bit)) && (ratio_idx == $past(mode_sel)));
    // R4
    hybrid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_act && auto_en && auto_state == DYN_HYBRID) |=> src_dyn && lock_ok && (ratio_idx == $past(ptr_act)));
    // R5
    synth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_act && auto_en && auto_state == REF_SYNTH) |=> !src_dyn && (ratio_idx == $past(mode_sel)));
endmodule

// File: tb/ratio_src_ctrl_tb_top.sv
module ratio_src_ctrl_tb_top;
    localparam int TMO = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = '0;
    logic [7:0] lock_ptr_flat = 8'b11_10_01_00;
    logic [3:0] man_src = '0;
    logic       ovr_pin = 1'b0;
    logic [2:0] ovr_cfg = '0;
    logic       in_clk = 1'b0;
    logic       ck_run = 1'b0;
    logic       src_dyn, lock_ok;
    logic [1:0] ratio_idx;

    int checks = 0, errors = 0;
    int low_cnt = 0;
    logic mon_en = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;
    always #30 if (ck_run) in_clk = ~in_clk;

    ratio_src_ctrl #(.TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .lock_ptr_flat(lock_ptr_flat),
        .man_src(man_src), .ovr_pin(ovr_pin), .ovr_cfg(ovr_cfg), .in_clk(in_clk),
        .src_dyn(src_dyn), .ratio_idx(ratio_idx), .lock_ok(lock_ok)
    );

    always @(negedge clk) if (mon_en && !lock_ok) low_cnt++;

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model(input logic [1:0] s, input logic [7:0] ptrs,
                                         input logic [3:0] man, input logic pin,
                                         input logic [2:0] cfg, input logic pres);
        logic [1:0] p;
        logic src;
        p = ptrs[s*2 +: 2];
        if (cfg == 3'b011) src = pin;
        else if (p == s)   src = man[s];
        else               src = pres;
        return {src, (src ? p : s), 1'b1};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rand_phase(input logic pres, input string tag);
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            mode_sel      = 2'($urandom);
            lock_ptr_flat = 8'($urandom);
            man_src       = 4'($urandom);
            ovr_pin       = 1'($urandom);
            ovr_cfg       = ($urandom % 3 == 0) ? 3'b011 : 3'($urandom);
            cyc(2);
            chk(tag, {src_dyn, ratio_idx, lock_ok},
                model(mode_sel, lock_ptr_flat, man_src, ovr_pin, ovr_cfg, pres));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1 reset values
        cyc(3);
        chk("R1", {src_dyn, ratio_idx, lock_ok}, 4'b0000);
        @(posedge clk); #1 rst_n = 1'b1;
        // R3 manual, slot 2 with pointer 2, manual bit 1
        mode_sel = 2'd2; man_src = 4'b0100;
        cyc(2);
        chk("R3", {src_dyn, ratio_idx, lock_ok}, 4'b1101);
        man_src = 4'b0000;
        cyc(2);
        chk("R3", {src_dyn, ratio_idx, lock_ok}, 4'b0101);
        // R9 override inactive with code 3'b111, active with 3'b011
        ovr_cfg = 3'b111; ovr_pin = 1'b1;
        cyc(2);
        chk("R9", {src_dyn, ratio_idx, lock_ok}, 4'b0101);
        ovr_cfg = 3'b011;
        cyc(2);
        chk("R9", {src_dyn, ratio_idx, lock_ok}, 4'b1101);
        ovr_cfg = 3'b000; ovr_pin = 1'b0;
        // R2/R5 automatic: slot 1 points at slot 3, clock absent
        mode_sel = 2'd1; lock_ptr_flat = 8'b11_10_11_00; man_src = 4'b0010;
        cyc(2);
        chk("R5", {src_dyn, ratio_idx, lock_ok}, 4'b0011);
        // R7/R8 clock return: one-cycle lock drop, then hybrid
        low_cnt = 0; mon_en = 1'b1; ck_run = 1'b1;
        cyc(150);
        mon_en = 1'b0;
        chk("R8", 4'(low_cnt), 4'd1);
        // R4 hybrid with pointer slot 3
        chk("R4", {src_dyn, ratio_idx, lock_ok}, 4'b1111);
        // R7 absence detection and R6 timeout window
        low_cnt = 0; mon_en = 1'b1; ck_run = 1'b0;
        cyc(10);
        chk("R7", {src_dyn, lock_ok}, 4'b0011);
        cyc(60);
        chk("R6", {src_dyn, lock_ok}, 4'b0010);
        cyc(TMO + 60);
        mon_en = 1'b0;
        chk("R6", 4'(low_cnt == TMO), 4'd1);
        if (low_cnt != TMO) $display("FAIL R6 low window actual=%0d expected=%0d", low_cnt, TMO);
        chk("R5", {src_dyn, ratio_idx, lock_ok}, 4'b0011);
        // random, clock absent (fallback state)
        rand_phase(1'b0, "R2/R5/R9 absent");
        // random, clock present
        ck_run = 1'b1;
        cyc(150);
        rand_phase(1'b1, "R2/R4/R9 present");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule